// File: doc/BRIEF.md
# Pseudo-SRAM Low-Power Mode Sequencer

This block is the device-side controller that decides how a pseudo-SRAM behaves while its active-low sleep input is held low. It watches the sleep input together with the chip-select and write-enable strobes, all synchronous to `clk`. A write strobe that arrives shortly after the sleep input falls is taken as a mode-register write. The five mode fields come from the low address bits, and the data bus plays no part. When the sleep input returns high after a long enough low period, the captured setting is committed.

Each later low period with no register write in its opening window leads to one of three outcomes, chosen from the committed setting: deep power-down, refresh of part of the array only, or full self-refresh. Leaving deep power-down puts every field back to its default and holds the block not-ready for a recovery interval. In reduced-size mode the configured address window also limits which addresses are valid for normal accesses, and an access outside it is flagged.

All times are counted in clock cycles by parameters. `WIN_CYC` is the write window, `MIN_LOW_CYC` the shortest legal sleep pulse and `RECOV_CYC` the recovery time after deep power-down.

Top module: `lp_mode_seq`

## Requirements
- R1: After reset the block reports `pwr_state` = 0 (active), `ready` = 1, range 0 to all-ones, and `oor`, `cfg_err` and `proto_err` all 0. The committed setting is the default: deep power-down off, partial mode, bottom half, full area.
- R2: A fall of `sleep_n` seen in the active state moves the block to `pwr_state` = 1 (window) with `ready` = 0 on the next cycle. The block stays in the window state for `WIN_CYC` further cycles, then moves to a decided low-power state.
- R3: A register write is a cycle with `cs_n` low and `we_n` low while `we_n` was high in the previous cycle. It is captured only if it falls in the same cycle as the sleep fall or in one of the following `WIN_CYC` cycles. The fields are taken from the address: bit 4 is deep power-down off (0 enables deep power-down), bit 3 is reduced-size mode, bit 2 selects the top half, and bits 1:0 are the area (00 full, 01 reserved, 10 half, 11 quarter). A strobe later in the low period is ignored.
- R4: A low period that captured a valid write is decided as full self-refresh (`pwr_state` = 2). The captured setting becomes committed when `sleep_n` rises at the end of that period.
- R5: A low period with no captured write is decided from the committed setting. If deep power-down is enabled the state is 4. Otherwise, partial mode with a non-full area gives 3 (partial refresh). Anything else gives 2.
- R6: `rng_lo`/`rng_hi` follow the committed setting. The full area gives the whole space, and the half bit is ignored there. A half area gives the lower or upper half. A quarter area gives the lowest or the highest quarter.
- R7: A rise of `sleep_n` in state 4 leads to state 5 (recovery) with `ready` = 0 for `RECOV_CYC` cycles, then to state 0. Every field returns to its default.
- R8: A low period shorter than `MIN_LOW_CYC` cycles sets the sticky `proto_err` and commits nothing. The block returns to state 0, or to state 5 if it was in state 4.
- R9: A captured write with area code 01, or with any address bit above bit 4 set, is discarded and sets the sticky `cfg_err`.
- R10: In state 0 with reduced-size mode committed, a cycle with `cs_n` low and `sleep_n` high whose address lies outside the range raises `oor` on the next cycle, for that one cycle. `oor` stays 0 for addresses inside the range and in partial mode.
- R11: A rise of `sleep_n` in any decided low-power state (2, 3 or 4) leaves it on the next cycle, for state 0 or 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n | input | 1 | Active-low sleep request |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W | Access address; low bits carry mode fields |
| pwr_state | output | 3 | 0 active, 1 window, 2 self-refresh, 3 partial, 4 deep, 5 recovery |
| ready | output | 1 | High when normal accesses are allowed |
| rng_lo | output | ADDR_W | Lowest address of the configured range |
| rng_hi | output | ADDR_W | Highest address of the configured range |
| oor | output | 1 | One-cycle out-of-window access flag |
| cfg_err | output | 1 | Sticky rejected register write |
| proto_err | output | 1 | Sticky short sleep pulse |

## Verification
The bench builds the block with `ADDR_W` = 6, `WIN_CYC` = 3, `MIN_LOW_CYC` = 8 and `RECOV_CYC` = 10. With an address space of 64 words, every one of the 32 register codes can be written and then exercised. For each code, every address is swept against the resulting window, and the expected bounds are computed from halves and quarters of 64. The short timing constants let the bench place write strobes at each offset inside the window and one cycle beyond it. They also allow a short sleep pulse and full deep power-down recovery to be checked in a few dozen cycles.

// File: rtl/lp_pkg.sv
package lp_pkg;

    typedef struct packed {
        logic       dpd_off;
        logic       rms;
        logic       top;
        logic [1:0] area;
    } lp_cfg_t;

    localparam lp_cfg_t CFG_DEFAULT = '{dpd_off: 1'b1, rms: 1'b0, top: 1'b0, area: 2'b00};

    typedef enum logic [2:0] {
        PS_ACTIVE  = 3'd0,
        PS_WINDOW  = 3'd1,
        PS_SELF    = 3'd2,
        PS_PARTIAL = 3'd3,
        PS_DEEP    = 3'd4,
        PS_RECOVER = 3'd5
    } lp_state_e;

    // Low-power state chosen for a sleep period with no register write.
    function automatic lp_state_e lp_decide(lp_cfg_t c);
        if (!c.dpd_off)
            return PS_DEEP;
        else if (!c.rms && (c.area != 2'b00))
            return PS_PARTIAL;
        else
            return PS_SELF;
    endfunction

endpackage

// File: rtl/lp_cfg_check.sv
module lp_cfg_check
    import lp_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  logic [ADDR_W-1:0] addr,
    output lp_cfg_t           cfg,
    output logic              ok
);
    localparam int FLD_W = $bits(lp_cfg_t);

    always_comb begin
        cfg = lp_cfg_t'(addr[FLD_W-1:0]);
        ok  = (addr[ADDR_W-1:FLD_W] == '0) && (addr[1:0] != 2'b01);
    end
endmodule

// File: rtl/lp_range_decode.sv
module lp_range_decode
    import lp_pkg::*;
#(
    parameter int ADDR_W = 21
) (
    input  lp_cfg_t           cfg,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam logic [ADDR_W-1:0] ALL_ONES = '1;
    localparam logic [ADDR_W-1:0] HALF     = {1'b1, {(ADDR_W-1){1'b0}}};
    localparam logic [ADDR_W-1:0] QTR      = {2'b01, {(ADDR_W-2){1'b0}}};
    localparam logic [ADDR_W-1:0] HALF_M1  = HALF - 1'b1;
    localparam logic [ADDR_W-1:0] QTR_M1   = QTR - 1'b1;
    localparam logic [ADDR_W-1:0] TOP_QTR  = HALF | QTR;

    always_comb begin
        lo = '0;
        hi = ALL_ONES;
        case (cfg.area)
            2'b10: begin
                lo = cfg.top ? HALF : '0;
                hi = cfg.top ? ALL_ONES : HALF_M1;
            end
            2'b11: begin
                lo = cfg.top ? TOP_QTR : '0;
                hi = cfg.top ? ALL_ONES : QTR_M1;
            end
            default: begin
                lo = '0;
                hi = ALL_ONES;
            end
        endcase
    end
endmodule

// File: rtl/lp_mode_seq.sv
module lp_mode_seq
    import lp_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int WIN_CYC     = 100,
    parameter int MIN_LOW_CYC = 1000,
    parameter int RECOV_CYC   = 20000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [2:0]        pwr_state,
    output logic              ready,
    output logic [ADDR_W-1:0] rng_lo,
    output logic [ADDR_W-1:0] rng_hi,
    output logic              oor,
    output logic              cfg_err,
    output logic              proto_err
);
    localparam int CNT_MAX0 = (WIN_CYC > MIN_LOW_CYC) ? WIN_CYC : MIN_LOW_CYC;
    localparam int CNT_MAX  = (CNT_MAX0 > RECOV_CYC) ? CNT_MAX0 : RECOV_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    typedef struct packed {
        lp_state_e        st;
        logic [CNT_W-1:0] cnt;
        lp_cfg_t          cfg;
        lp_cfg_t          pend;
        logic             pend_v;
        logic             wrote;
        logic             sleep_p;
        logic             we_p;
        logic             oor;
        logic             cfg_err;
        logic             proto_err;
    } seq_t;

    seq_t r_q, r_d;

    lp_cfg_t            wr_cfg;
    logic               wr_ok;
    logic [ADDR_W-1:0]  lo_w, hi_w;

    lp_cfg_check #(.ADDR_W(ADDR_W)) u_check (
        .addr (addr),
        .cfg  (wr_cfg),
        .ok   (wr_ok)
    );

    lp_range_decode #(.ADDR_W(ADDR_W)) u_range (
        .cfg (r_q.cfg),
        .lo  (lo_w),
        .hi  (hi_w)
    );

    logic fall, rise, wstb, win_open, capture, short_low, wrote_now, in_low;

    always_comb begin
        fall      = r_q.sleep_p & ~sleep_n;
        rise      = ~r_q.sleep_p & sleep_n;
        wstb      = ~cs_n & ~we_n & r_q.we_p;
        win_open  = ~sleep_n & ((r_q.st == PS_WINDOW) || ((r_q.st == PS_ACTIVE) && fall));
        capture   = wstb & win_open;
        wrote_now = r_q.wrote | (capture & wr_ok);
        short_low = r_q.cnt < CNT_W'(MIN_LOW_CYC - 1);
        in_low    = (r_q.st == PS_WINDOW) || (r_q.st == PS_SELF) ||
                    (r_q.st == PS_PARTIAL) || (r_q.st == PS_DEEP);

        r_d         = r_q;
        r_d.sleep_p = sleep_n;
        r_d.we_p    = we_n;
        r_d.oor     = 1'b0;

        if (in_low && r_q.cnt != CNT_W'(CNT_MAX))
            r_d.cnt = r_q.cnt + 1'b1;

        case (r_q.st)
            PS_ACTIVE: begin
                if (fall) begin
                    r_d.st     = PS_WINDOW;
                    r_d.cnt    = '0;
                    r_d.wrote  = 1'b0;
                    r_d.pend_v = 1'b0;
                end else if (~cs_n && sleep_n && r_q.cfg.rms &&
                             ((addr < lo_w) || (addr > hi_w))) begin
                    r_d.oor = 1'b1;
                end
            end
            PS_WINDOW: begin
                if (!rise && r_q.cnt == CNT_W'(WIN_CYC - 1))
                    r_d.st = wrote_now ? PS_SELF : lp_decide(r_q.cfg);
            end
            PS_RECOVER: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == CNT_W'(RECOV_CYC - 1)) begin
                    r_d.st  = PS_ACTIVE;
                    r_d.cnt = '0;
                end
            end
            default: ;
        endcase

        if (in_low && rise) begin
            r_d.cnt    = '0;
            r_d.pend_v = 1'b0;
            r_d.st     = (r_q.st == PS_DEEP) ? PS_RECOVER : PS_ACTIVE;
            if (short_low)
                r_d.proto_err = 1'b1;
            else if (r_q.st == PS_DEEP)
                r_d.cfg = CFG_DEFAULT;
            else if (r_q.pend_v)
                r_d.cfg = r_q.pend;
        end

        if (capture) begin
            if (wr_ok) begin
                r_d.pend   = wr_cfg;
                r_d.pend_v = 1'b1;
                r_d.wrote  = 1'b1;
            end else begin
                r_d.cfg_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= PS_ACTIVE;
            r_q.cfg       <= CFG_DEFAULT;
            r_q.pend      <= CFG_DEFAULT;
            r_q.sleep_p   <= 1'b1;
            r_q.we_p      <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign pwr_state = r_q.st;
    assign ready     = (r_q.st == PS_ACTIVE);
    assign rng_lo    = lo_w;
    assign rng_hi    = hi_w;
    assign oor       = r_q.oor;
    assign cfg_err   = r_q.cfg_err;
    assign proto_err = r_q.proto_err;

endmodule

// File: rtl/lp_mode_seq_chk.sv
module lp_mode_seq_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_n,
    input logic              cs_n,
    input logic [2:0]        pwr_state,
    input logic              ready,
    input logic [ADDR_W-1:0] rng_lo,
    input logic [ADDR_W-1:0] rng_hi,
    input logic              oor,
    input logic              cfg_err,
    input logic              proto_err
);
    p_ready_to_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> pwr_state == 3'd1);

    p_range_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rng_lo <= rng_hi);

    p_deep_to_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state == 3'd4 && sleep_n) |=> pwr_state == 3'd5);

    p_proto_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    p_cfg_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_oor_after_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oor |-> ($past(ready) && !$past(cs_n)));

    p_low_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_state == 3'd2 || pwr_state == 3'd3 || pwr_state == 3'd4) && sleep_n)
        |=> (pwr_state == 3'd0 || pwr_state == 3'd5));
endmodule

bind lp_mode_seq lp_mode_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_n   (sleep_n),
    .cs_n      (cs_n),
    .pwr_state (pwr_state),
    .ready     (ready),
    .rng_lo    (rng_lo),
    .rng_hi    (rng_hi),
    .oor       (oor),
    .cfg_err   (cfg_err),
    .proto_err (proto_err)
);

// File: tb/lp_mode_seq_tb_top.sv
module lp_mode_seq_tb_top;
    localparam int AW   = 6;
    localparam int WIN  = 3;
    localparam int MINL = 8;
    localparam int REC  = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_n = 1'b1;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [2:0]    pwr_state;
    logic          ready, oor, cfg_err, proto_err;
    logic [AW-1:0] rng_lo, rng_hi;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [4:0] ecfg = 5'b10000;
    bit   ecerr = 1'b0;
    bit   eperr = 1'b0;

    always #5 clk = ~clk;

    lp_mode_seq #(.ADDR_W(AW), .WIN_CYC(WIN), .MIN_LOW_CYC(MINL), .RECOV_CYC(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cs_n(cs_n), .we_n(we_n),
        .addr(addr), .pwr_state(pwr_state), .ready(ready), .rng_lo(rng_lo),
        .rng_hi(rng_hi), .oor(oor), .cfg_err(cfg_err), .proto_err(proto_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int dec(input logic [4:0] c);
        if (!c[4]) return 4;
        if (!c[3] && c[1:0] != 2'b00) return 3;
        return 2;
    endfunction

    function automatic int elo(input logic [4:0] c);
        if (c[1:0] == 2'b10) return c[2] ? 32 : 0;
        if (c[1:0] == 2'b11) return c[2] ? 48 : 0;
        return 0;
    endfunction

    function automatic int ehi(input logic [4:0] c);
        if (c[1:0] == 2'b10) return c[2] ? 63 : 31;
        if (c[1:0] == 2'b11) return c[2] ? 63 : 15;
        return 63;
    endfunction

    task automatic check_static(input string tag);
        chk({"R6 rng_lo ", tag}, int'(rng_lo), elo(ecfg));
        chk({"R6 rng_hi ", tag}, int'(rng_hi), ehi(ecfg));
        chk({"R9 cfg_err ", tag}, int'(cfg_err), int'(ecerr));
        chk({"R8 proto_err ", tag}, int'(proto_err), int'(eperr));
    endtask

    // d < 0: no write strobe. low: number of cycles sleep_n is sampled low.
    task automatic low_period(input int d, input logic [AW-1:0] a, input int low);
        bit ok, cap, badcap, shrt;
        int exp_dec, exp_after;
        ok      = (a[AW-1:5] == '0) && (a[1:0] != 2'b01);
        cap     = ok && d >= 0 && d <= WIN;
        badcap  = !ok && d >= 0 && d <= WIN;
        exp_dec = cap ? 2 : dec(ecfg);
        shrt    = low < MINL;
        sleep_n = 1'b0;
        if (d == 0) begin cs_n = 1'b0; we_n = 1'b0; addr = a; end
        tick();
        chk("R2 window state", int'(pwr_state), 1);
        chk("R2 ready low", int'(ready), 0);
        if (d == 0) begin cs_n = 1'b1; we_n = 1'b1; end
        for (int k = 1; k < low; k++) begin
            if (k == d) begin cs_n = 1'b0; we_n = 1'b0; addr = a; end
            tick();
            if (k == d) begin cs_n = 1'b1; we_n = 1'b1; end
            if (k < WIN)
                chk("R2 still window", int'(pwr_state), 1);
            else if (k == WIN)
                chk(cap ? "R4 written period self-refresh" : "R5 decided state",
                    int'(pwr_state), exp_dec);
        end
        if (badcap) ecerr = 1'b1;
        sleep_n = 1'b1;
        tick();
        exp_after = (exp_dec == 4 && low > WIN) ? 5 : 0;
        if (shrt) eperr = 1'b1;
        else if (exp_after == 5) ecfg = 5'b10000;
        else if (cap) ecfg = a[4:0];
        chk(shrt ? "R8 state after short" : "R11 state after rise",
            int'(pwr_state), exp_after);
        check_static(cap ? "R3 after write" : "after period");
        if (exp_after == 5) begin
            repeat (REC - 1) tick();
            chk("R7 still recovering", int'(pwr_state), 5);
            chk("R7 not ready", int'(ready), 0);
            tick();
            chk("R7 back active", int'(pwr_state), 0);
            chk("R7 ready", int'(ready), 1);
        end
    endtask

    task automatic oor_sweep();
        for (int a = 0; a < 64; a++) begin
            cs_n = 1'b0;
            addr = AW'(a);
            tick();
            chk("R10 oor", int'(oor),
                int'(ecfg[3] && (a < elo(ecfg) || a > ehi(ecfg))));
        end
        cs_n = 1'b1;
        tick();
        chk("R10 oor single cycle", int'(oor), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1..: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset state", int'(pwr_state), 0);
        chk("R1 reset ready", int'(ready), 1);
        chk("R1 reset oor", int'(oor), 0);
        check_static("R1 reset");

        // R3: strobe one cycle past the window is ignored.
        low_period(WIN + 1, 6'h0A, 10);
        // R8: short pulse with a valid write commits nothing.
        low_period(1, 6'h0B, 4);
        // R9: upper address bit set rejects the write.
        low_period(2, 6'h2A, 10);
        oor_sweep();

        for (int c = 0; c < 32; c++) begin
            low_period(c % (WIN + 1), AW'(c), 10);
            oor_sweep();
            low_period(-1, '0, 10);
        end

        // R8: short pulse while in deep power-down keeps the setting.
        low_period(0, 6'h03, 10);
        low_period(-1, '0, 6);
        chk("R8 setting kept after short deep pulse", int'(ecfg), 3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule